// File: doc/BRIEF.md
# Endian-Aware Load/Store Alignment Unit

This unit sits between a 64-bit core datapath and a byte-addressable data memory that is 64 bits wide. It carries out loads and stores of 1, 2, 4 or 8 bytes at any byte address. The byte order is chosen at run time by a mode input. A store is turned into lane-placed write data plus a byte-enable vector. A load collects the addressed bytes, orders them by the selected byte order, and widens the result to 64 bits with zeros or with copies of the sign bit.

An access whose bytes fit inside one doubleword takes one memory beat. An access that crosses a doubleword boundary is split into two aligned beats, lower doubleword first, and the two halves are merged into one result. The core hands over a request with a valid/ready handshake and sees a one-cycle completion pulse. The memory port is one with a combinational read. The unit captures read data at the clock edge that ends each beat.

Top module: `lsu_align`

## Requirements
- R1: `req_size_i` encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R2: A load narrower than 8 bytes fills the upper result bytes with copies of the value's top bit when `req_signed_i` is 1, and with zeros when it is 0.
- R3: With `big_endian_i` at 0, the byte at the lowest address is the least significant byte of the value. With it at 1, that byte is the most significant. The mode is sampled when the request is accepted.
- R4: An access whose byte offset within its doubleword plus its size is at most 8 uses exactly one beat. Its `mem_addr_o` is the request address with the low three bits cleared.
- R5: An access whose offset plus size exceeds 8 uses exactly two beats in consecutive cycles. The first beat goes to the lower doubleword and the second to the address 8 above it.
- R6: In every beat, bit k of `mem_be_o` is set exactly when the byte at lane k of that doubleword belongs to the access. A store writes the addressed bytes with the value placed in byte order and leaves every other memory byte unchanged.
- R7: `done_o` is high for exactly one cycle, the cycle after the last beat. In that cycle `rdata_o` holds the load result and `split_o` is 1 exactly when the access took two beats.
- R8: `req_ready_o` is high only while the unit is idle. A request presented while the unit is busy is not taken and causes no memory beat.
- R9: After reset, `req_ready_o` is 1 and `mem_req_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| big_endian_i | input | 1 | Byte order mode, 1 selects big-endian |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle and able to take a request |
| req_we_i | input | 1 | 1 for a store, 0 for a load |
| req_size_i | input | 2 | Access width code |
| req_signed_i | input | 1 | Sign-extend a narrow load |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store value, right-aligned |
| done_o | output | 1 | Completion pulse |
| split_o | output | 1 | Access used two beats, valid with done_o |
| rdata_o | output | DATA_W | Load result, valid with done_o |
| mem_req_o | output | 1 | Memory beat active |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | ADDR_W | Doubleword-aligned memory address |
| mem_be_o | output | DATA_W/8 | Byte enables of the beat |
| mem_wdata_o | output | DATA_W | Lane-placed write data |
| mem_rdata_i | input | DATA_W | Memory read data, same cycle as the beat |

## Verification
A wrong byte offset or size held in the unit shows at the ports in the first beat: one cycle after acceptance, as a byte-enable pattern that does not match the addressed lanes. A wrong split decision shows one cycle later, as a missing or extra beat, a second address that is not 8 above the first, or a `split_o` flag that disagrees. Lane or byte-order mistakes show only at completion, in `rdata_o`, or as changed memory bytes after a store. For that reason every access is compared against an independent byte-level memory model, both in its result and in every memory byte.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BEAT0,
    ST_BEAT1,
    ST_DONE
  } lsu_state_e;

  typedef struct packed {
    logic      we;
    acc_size_e size;
    logic      sgn;
    logic      big_end;
  } acc_attr_t;

  function automatic int size_bytes(acc_size_e s);
    return 32'sd1 << s;
  endfunction

endpackage

// File: rtl/lsu_align_span.sv
// Byte mask of an access over a two-doubleword window, plus boundary crossing.
module lsu_align_span
  import lsu_align_pkg::*;
#(
  parameter int NB = 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0] off_i,
  input  acc_size_e        size_i,
  output logic [2*NB-1:0]  mask_o,
  output logic             split_o
);
  int lo, hi;

  always_comb begin
    lo      = int'(off_i);
    hi      = lo + size_bytes(size_i);
    split_o = hi > NB;
  end

  for (genvar p = 0; p < 2*NB; p++) begin : g_pos
    assign mask_o[p] = (p >= lo) && (p < hi);
  end

endmodule

// File: rtl/lsu_align_store.sv
// Orders store bytes by mode and places them into the two-doubleword window.
module lsu_align_store
  import lsu_align_pkg::*;
#(
  parameter int NB = 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              big_end_i,
  input  logic [8*NB-1:0]   wdata_i,
  output logic [16*NB-1:0]  span_o
);
  logic [7:0] strm [NB];

  always_comb begin
    int n;
    n = size_bytes(size_i);
    for (int j = 0; j < NB; j++) begin
      if (j < n) strm[j] = big_end_i ? wdata_i[8*(n-1-j) +: 8] : wdata_i[8*j +: 8];
      else       strm[j] = '0;
    end
  end

  for (genvar p = 0; p < 2*NB; p++) begin : g_lane
    logic [7:0] b;
    always_comb begin
      int rel;
      rel = p - int'(off_i);
      b   = (rel >= 0 && rel < NB) ? strm[rel[OFF_W-1:0]] : '0;
    end
    assign span_o[8*p +: 8] = b;
  end

endmodule

// File: rtl/lsu_align_load.sv
// Extracts load bytes from the window, applies byte order and extension.
module lsu_align_load
  import lsu_align_pkg::*;
#(
  parameter int NB = 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  acc_size_e         size_i,
  input  logic              big_end_i,
  input  logic              sgn_i,
  input  logic [16*NB-1:0]  span_i,
  output logic [8*NB-1:0]   data_o
);
  logic [7:0] strm [NB];
  logic       fill;
  int         n;

  always_comb begin
    for (int j = 0; j < NB; j++) strm[j] = span_i[8*(int'(off_i) + j) +: 8];
  end

  always_comb begin
    n    = size_bytes(size_i);
    fill = sgn_i & (big_end_i ? strm[0][7] : strm[n-1][7]);
  end

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] b;
    always_comb begin
      int src;
      src = big_end_i ? (n - 1 - i) : i;
      if (i < n) b = strm[src[OFF_W-1:0]];
      else       b = {8{fill}};
    end
    assign data_o[8*i +: 8] = b;
  end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                big_endian_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_we_i,
  input  logic [1:0]          req_size_i,
  input  logic                req_signed_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                done_o,
  output logic                split_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  lsu_state_e          state_q, state_d;
  acc_attr_t           attr_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [2*DATA_W-1:0] rspan_q;

  logic [OFF_W-1:0]    off;
  logic [2*NB-1:0]     mask;
  logic                split;
  logic [2*DATA_W-1:0] wspan;
  logic [DATA_W-1:0]   ld_data;
  logic                beat0, beat1;
  logic [ADDR_W-1:0]   base;

  assign off = addr_q[OFF_W-1:0];

  lsu_align_span #(.NB(NB)) u_span (
    .off_i  (off),
    .size_i (attr_q.size),
    .mask_o (mask),
    .split_o(split)
  );

  lsu_align_store #(.NB(NB)) u_store (
    .off_i    (off),
    .size_i   (attr_q.size),
    .big_end_i(attr_q.big_end),
    .wdata_i  (wdata_q),
    .span_o   (wspan)
  );

  lsu_align_load #(.NB(NB)) u_load (
    .off_i    (off),
    .size_i   (attr_q.size),
    .big_end_i(attr_q.big_end),
    .sgn_i    (attr_q.sgn),
    .span_i   (rspan_q),
    .data_o   (ld_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_BEAT0;
      ST_BEAT0: state_d = split ? ST_BEAT1 : ST_DONE;
      ST_BEAT1: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      attr_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rspan_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        attr_q  <= '{we: req_we_i, size: acc_size_e'(req_size_i),
                     sgn: req_signed_i, big_end: big_endian_i};
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (beat0) rspan_q[DATA_W-1:0]        <= mem_rdata_i;
      if (beat1) rspan_q[2*DATA_W-1:DATA_W] <= mem_rdata_i;
    end
  end

  assign beat0 = (state_q == ST_BEAT0);
  assign beat1 = (state_q == ST_BEAT1);
  assign base  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = beat0 | beat1;
  assign mem_we_o    = mem_req_o & attr_q.we;
  assign mem_addr_o  = beat1 ? base + ADDR_W'(NB) : base;
  assign mem_be_o    = beat1 ? mask[2*NB-1:NB] : (beat0 ? mask[NB-1:0] : '0);
  assign mem_wdata_o = beat1 ? wspan[2*DATA_W-1:DATA_W] : wspan[DATA_W-1:0];

  assign done_o  = (state_q == ST_DONE);
  assign split_o = done_o & split;
  assign rdata_o = done_o ? ld_data : '0;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic [ADDR_W-1:0]   req_addr_i,
  input logic                done_o,
  input logic                split_o,
  input logic                mem_req_o,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [DATA_W/8-1:0] mem_be_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  p_busy_not_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_accept_first_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=>
      (mem_req_o && mem_addr_o[OFF_W-1:0] == '0 &&
       mem_addr_o[ADDR_W-1:OFF_W] == $past(req_addr_i[ADDR_W-1:OFF_W])));

  p_second_beat_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o)) |-> mem_addr_o == $past(mem_addr_o) + ADDR_W'(NB));

  p_split_two_beats_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && split_o) |-> ($past(mem_req_o) && $past(mem_req_o, 2)));

  p_be_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_be_o != '0);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_after_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_req_o) && !mem_req_o));

endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_addr_i (req_addr_i),
  .done_o     (done_o),
  .split_o    (split_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_o   (mem_be_o)
);

// File: tb/lsu_align_tb.sv
module lsu_align_tb;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          big_endian = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_we = 1'b0;
  logic [1:0]    req_size = '0;
  logic          req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done, split;
  logic [DW-1:0] rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_be;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  lsu_align u_dut (
    .clk_i(clk), .rst_ni(rst_n), .big_endian_i(big_endian),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_size_i(req_size), .req_signed_i(req_signed), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .done_o(done), .split_o(split), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // byte memory model, 64 bytes, combinational read
  logic [7:0] mem_q [64];
  logic [7:0] exp_mem [64];

  function automatic logic [7:0] init_byte(int i);
    return 8'(i * 37 + 145);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem_q[i] <= init_byte(i);
    end else if (mem_req && mem_we) begin
      for (int k = 0; k < 8; k++)
        if (mem_be[k]) mem_q[{mem_addr[5:3], 3'(k)}] <= mem_wdata[8*k +: 8];
    end
  end

  always_comb begin
    for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem_q[{mem_addr[5:3], 3'(k)}];
  end

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sgn;
    logic        be;
    logic [5:0]  addr;
    logic [63:0] wd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd3, 1'b0, 1'b0, 6'd8,  64'h0},                 // D aligned LE
    '{1'b0, 2'd3, 1'b0, 1'b1, 6'd16, 64'h0},                 // D aligned BE
    '{1'b0, 2'd0, 1'b1, 1'b0, 6'd3,  64'h0},                 // B signed
    '{1'b0, 2'd0, 1'b0, 1'b1, 6'd5,  64'h0},                 // B unsigned
    '{1'b0, 2'd1, 1'b1, 1'b1, 6'd6,  64'h0},                 // H signed BE
    '{1'b0, 2'd1, 1'b1, 1'b0, 6'd7,  64'h0},                 // H split LE
    '{1'b0, 2'd2, 1'b1, 1'b0, 6'd2,  64'h0},                 // W misaligned, one beat
    '{1'b0, 2'd2, 1'b0, 1'b1, 6'd13, 64'h0},                 // W split BE
    '{1'b0, 2'd3, 1'b0, 1'b0, 6'd27, 64'h0},                 // D split LE
    '{1'b1, 2'd2, 1'b0, 1'b0, 6'd33, 64'h1122_3344_A1B2_C3D4},
    '{1'b1, 2'd1, 1'b0, 1'b1, 6'd47, 64'h0000_0000_0000_8E5A},
    '{1'b1, 2'd3, 1'b0, 1'b1, 6'd50, 64'h0123_4567_89AB_CDEF},
    '{1'b1, 2'd0, 1'b0, 1'b0, 6'd60, 64'hFFFF_FFFF_FFFF_FF77},
    '{1'b0, 2'd3, 1'b0, 1'b1, 6'd50, 64'h0},                 // read back BE store
    '{1'b0, 2'd2, 1'b1, 1'b1, 6'd47, 64'h0}                  // W split signed BE
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected load value from the byte model (R1, R2, R3)
  function automatic logic [63:0] ref_load(logic [5:0] a, logic [1:0] sz, logic sgn, logic be);
    int n;
    logic [63:0] v;
    n = 1 << sz;
    v = '0;
    for (int i = 0; i < n; i++) begin
      int sig;
      sig = be ? n - 1 - i : i;
      v[8*sig +: 8] = exp_mem[6'(a + 6'(i))];
    end
    if (sgn && n < 8 && v[8*n-1]) for (int i = n; i < 8; i++) v[8*i +: 8] = 8'hFF;
    return v;
  endfunction

  function automatic logic [7:0] ref_mask(logic [5:0] a, logic [1:0] sz, int beat);
    logic [7:0] m;
    int off, n;
    off = int'(a[2:0]);
    n = 1 << sz;
    for (int k = 0; k < 8; k++) m[k] = (8*beat + k >= off) && (8*beat + k < off + n);
    return m;
  endfunction

  task automatic run_access(input vec_t v, output int beats, output int done_at,
                            output logic [AW-1:0] a0, output logic [AW-1:0] a1,
                            output logic [7:0] b0, output logic [7:0] b1,
                            output logic [63:0] rd, output logic sp);
    beats = 0; done_at = -1; a0 = '0; a1 = '0; b0 = '0; b1 = '0; rd = '0; sp = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = v.we; req_size = v.sz; req_signed = v.sgn;
    req_addr = AW'(v.addr); req_wdata = v.wd; big_endian = v.be;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 8; c++) begin
      if (done) begin
        done_at = c; rd = rdata; sp = split;
        break;
      end
      if (mem_req) begin
        if (beats == 0) begin a0 = mem_addr; b0 = mem_be; end
        else            begin a1 = mem_addr; b1 = mem_be; end
        beats++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int beats, done_at;
    logic [AW-1:0] a0, a1;
    logic [7:0] b0, b1;
    logic [63:0] rd;
    logic sp;

    for (int i = 0; i < 64; i++) exp_mem[i] = init_byte(i);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready === 1'b1, "R9 ready", 64'(req_ready), 64'd1);
    chk(mem_req === 1'b0 && done === 1'b0, "R9 idle", {62'd0, mem_req, done}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int t = 0; t < NV; t++) begin
      vec_t v;
      int n, exp_beats;
      logic [63:0] exp_v;
      logic [AW-1:0] base;
      v = VECS[t];
      n = 1 << v.sz;
      exp_beats = (int'(v.addr[2:0]) + n > 8) ? 2 : 1;
      exp_v = ref_load(v.addr, v.sz, v.sgn, v.be);
      base = AW'({v.addr[5:3], 3'b000});
      run_access(v, beats, done_at, a0, a1, b0, b1, rd, sp);

      if (exp_beats == 1) chk(beats == 1, "R4 beat count", 64'(beats), 64'd1);
      else                chk(beats == 2, "R5 beat count", 64'(beats), 64'd2);
      chk(a0 == base, "R4 first address", 64'(a0), 64'(base));
      if (exp_beats == 2) chk(a1 == base + 8, "R5 second address", 64'(a1), 64'(base + 8));
      chk(b0 == ref_mask(v.addr, v.sz, 0), "R6 byte enables beat0", 64'(b0), 64'(ref_mask(v.addr, v.sz, 0)));
      if (exp_beats == 2)
        chk(b1 == ref_mask(v.addr, v.sz, 1), "R6 byte enables beat1", 64'(b1), 64'(ref_mask(v.addr, v.sz, 1)));
      chk(done_at == beats, "R7 done timing", 64'(done_at), 64'(beats));
      chk(sp == (exp_beats == 2), "R7 split flag", 64'(sp), 64'(exp_beats == 2));

      if (!v.we) begin
        chk(rd == exp_v, "R1 R2 R3 load value", rd, exp_v);
      end else begin
        int bad;
        for (int i = 0; i < n; i++) exp_mem[6'(v.addr + 6'(i))] = v.wd[8*(v.be ? n - 1 - i : i) +: 8];
        bad = 0;
        for (int i = 0; i < 64; i++) if (mem_q[i] !== exp_mem[i]) bad++;
        chk(bad == 0, "R6 R3 store memory image", 64'(bad), 64'd0);
      end
    end

    // R8 request while busy is ignored; R3 mode sampled at acceptance
    begin
      int extra;
      logic [63:0] exp_v;
      exp_v = ref_load(6'd8, 2'd3, 1'b0, 1'b0);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_we = 1'b0; req_size = 2'd3; req_signed = 1'b0;
      req_addr = 32'd8; big_endian = 1'b0;
      @(negedge clk);
      req_we = 1'b1; req_addr = 32'd0; req_wdata = '1; big_endian = 1'b1;
      chk(req_ready === 1'b0, "R8 ready low while busy", 64'(req_ready), 64'd0);
      @(negedge clk);
      req_valid = 1'b0;
      chk(done === 1'b1, "R7 done after single beat", 64'(done), 64'd1);
      chk(rdata == exp_v, "R3 mode sampled at accept", rdata, exp_v);
      extra = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (mem_req) extra++;
      end
      chk(extra == 0, "R8 busy request no beat", 64'(extra), 64'd0);
      extra = 0;
      for (int i = 0; i < 8; i++) if (mem_q[i] !== exp_mem[i]) extra++;
      chk(extra == 0, "R8 busy request no write", 64'(extra), 64'd0);
      big_endian = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule